// File: doc/BRIEF.md
# Capability Revocation Sweep Engine

This block gives a tagged-capability memory system a hardware path for temporal safety. Software returns freed heap regions through a valid/ready free port. Each accepted region is held in quarantine rather than made reusable. At the same moment, every 16-byte heap granule that the region touches is marked in an internal shadow bitmap, which has one bit per granule of a fixed heap window.

When the quarantine reaches its configured depth, the engine stops taking frees and walks a configured range of memory words, one read at a time. For each word with its tag set, the engine takes the capability's base address from the low bits of the word and looks it up in the bitmap. The cursor bits play no part in the decision. If the granule of the base is marked, the engine writes the word back with its tag cleared. At the end of the walk the engine raises a one-cycle done pulse and reports how many tags it cleared. It then empties the quarantine and wipes the bitmap, so the quarantined regions become reusable.

Top module: `capRevoker`

## Requirements
- R1: After reset, freeReady is 1, done is 0, revokedCount is 0, and neither memEn nor memWe is asserted.
- R2: A free is accepted on a clock edge where freeValid and freeReady are both 1. freeReady stays 1 and no memory access takes place until the QDEPTH-th free is accepted (default 4).
- R3: From the cycle after the quarantine fills until the sweep ends, freeReady is 0. A freeValid during that time is ignored and does not count toward the next quarantine.
- R4: A tagged word in the sweep range whose base granule is marked is written back with the same data and tag 0.
- R5: The base is bits [15:0] of the word. Bits [31:16] hold the cursor and never influence revocation.
- R6: Untagged words are never written. Tagged words whose base is below HEAP_BASE, or at or above HEAP_BASE + 16*HEAP_GRANULES (default 0x1000 to 0x1400), are never revoked.
- R7: A region of length L at byte address B marks every granule from floor(B/16) to floor((B+L-1)/16), relative to HEAP_BASE. This includes partial first and last granules.
- R8: The sweep of W words lasts 2W+2 cycles after the accepting edge. done is high only in the last of those cycles, and revokedCount then equals the number of tags cleared. revokedCount holds its value while the engine is idle.
- R9: After a sweep, the bitmap is empty. Regions from earlier rounds no longer cause any revocation.
- R10: The parts of a region outside the heap window mark nothing. A region lying wholly outside the window marks no granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeValid | input | 1 | Free request valid |
| freeReady | output | 1 | Engine idle and accepting frees |
| freeBase | input | BASE_W | Byte address of the freed region |
| freeLen | input | LEN_W | Length of the freed region in bytes |
| sweepBase | input | MADDR_W | First word address of the sweep range |
| sweepWords | input | MADDR_W+1 | Number of words to sweep |
| memEn | output | 1 | Read request; data returns on the next cycle |
| memWe | output | 1 | Write request |
| memAddr | output | MADDR_W | Word address for read or write |
| memWData | output | WORD_W | Write data (the word as read) |
| memWTag | output | 1 | Write tag (always 0: revoke) |
| memRData | input | WORD_W | Read data, one cycle after memEn |
| memRTag | input | 1 | Tag of the read word |
| done | output | 1 | One-cycle pulse at sweep end |
| revokedCount | output | MADDR_W+1 | Tags cleared in the last sweep |

## Verification
The assertions assume that the memory returns read data exactly one cycle after memEn. They also assume that sweepBase and sweepWords stay stable while a sweep is running. The bench's memory model honours the fixed latency and only changes the range inputs while the engine is idle. The checks further assume that freeLen is nonzero and that the sweep range never wraps past the top of memory, and every stimulus region and range keeps to both. Free requests raised during a sweep are deliberately held high, so the bench can confirm they are dropped rather than queued.

// File: rtl/capRevPkg.sv
package capRevPkg;
  typedef struct packed {
    logic acceptFree;
    logic loadAddr;
    logic issueRead;
    logic evalWord;
    logic stepAddr;
    logic finish;
  } sweepStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_READ,
    S_EVAL,
    S_FIN
  } sweepState_t;
endpackage

// File: rtl/capRevCtrl.sv
module capRevCtrl
  import capRevPkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          freeValid,
  input  logic          qLast,
  input  logic          lastWord,
  input  logic          sweepEmpty,
  output sweepStrobes_t strobes,
  output logic          freeReady,
  output logic          done
);
  sweepState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    freeReady = (state == S_IDLE);
    done      = (state == S_FIN);
    case (state)
      S_IDLE: begin
        if (freeValid) begin
          strobes.acceptFree = 1'b1;
          if (qLast) nextState = S_SETUP;
        end
      end
      S_SETUP: begin
        strobes.loadAddr = 1'b1;
        nextState = sweepEmpty ? S_FIN : S_READ;
      end
      S_READ: begin
        strobes.issueRead = 1'b1;
        nextState = S_EVAL;
      end
      S_EVAL: begin
        strobes.evalWord = 1'b1;
        if (lastWord) begin
          nextState = S_FIN;
        end else begin
          strobes.stepAddr = 1'b1;
          nextState = S_READ;
        end
      end
      S_FIN: begin
        strobes.finish = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/capRevDatapath.sv
module capRevDatapath
  import capRevPkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int BASE_W         = 16,
  parameter int LEN_W          = 16,
  parameter int MADDR_W        = 8,
  parameter int HEAP_BASE      = 'h1000,
  parameter int HEAP_GRANULES  = 64,
  parameter int GRANULE_BYTES  = 16,
  parameter int QDEPTH         = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sweepStrobes_t        strobes,
  input  logic [BASE_W-1:0]    freeBase,
  input  logic [LEN_W-1:0]     freeLen,
  input  logic [MADDR_W-1:0]   sweepBase,
  input  logic [MADDR_W:0]     sweepWords,
  input  logic [WORD_W-1:0]    memRData,
  input  logic                 memRTag,
  output logic                 qLast,
  output logic                 lastWord,
  output logic                 sweepEmpty,
  output logic                 memEn,
  output logic                 memWe,
  output logic [MADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]    memWData,
  output logic                 memWTag,
  output logic [MADDR_W:0]     revokedCount
);
  localparam int GRAN_SHIFT = $clog2(GRANULE_BYTES);
  localparam int QCNT_W     = $clog2(QDEPTH + 1);
  localparam int CNT_W      = MADDR_W + 1;
  localparam int EXT_W      = ((BASE_W > LEN_W) ? BASE_W : LEN_W) + 1;
  localparam logic [EXT_W-1:0] HB_X   = EXT_W'(HEAP_BASE);
  localparam logic [EXT_W-1:0] HEND_X = EXT_W'(HEAP_BASE + HEAP_GRANULES * GRANULE_BYTES);

  logic [HEAP_GRANULES-1:0] bitmap;
  logic [HEAP_GRANULES-1:0] paintMask;
  logic [HEAP_GRANULES-1:0] hitVec;
  logic [QCNT_W-1:0]        qCount;
  logic [MADDR_W-1:0]       curAddr;
  logic [CNT_W-1:0]         wordIdx;
  logic [CNT_W-1:0]         revCount;

  // region painting: clip to heap window, then granule span
  logic [EXT_W-1:0] rStart, rEnd, lo, hi, gLo, gHi;
  logic             regionHit;

  always_comb begin
    rStart    = EXT_W'(freeBase);
    rEnd      = rStart + EXT_W'(freeLen) - EXT_W'(1);
    regionHit = (freeLen != '0) && (rStart < HEND_X) && (rEnd >= HB_X);
    lo        = (rStart < HB_X) ? HB_X : rStart;
    hi        = (rEnd >= HEND_X) ? (HEND_X - EXT_W'(1)) : rEnd;
    gLo       = (lo - HB_X) >> GRAN_SHIFT;
    gHi       = (hi - HB_X) >> GRAN_SHIFT;
  end

  // capability base lookup
  logic [EXT_W-1:0] capBase, gSel;
  logic             inHeap, revokeHit;

  always_comb begin
    capBase = EXT_W'(memRData[BASE_W-1:0]);
    inHeap  = (capBase >= HB_X) && (capBase < HEND_X);
    gSel    = (capBase - HB_X) >> GRAN_SHIFT;
  end

  for (genvar g = 0; g < HEAP_GRANULES; g++) begin : gGran
    assign paintMask[g] = regionHit && (gLo <= EXT_W'(g)) && (gHi >= EXT_W'(g));
    assign hitVec[g]    = bitmap[g] && (gSel == EXT_W'(g));
  end

  assign revokeHit = memRTag && inHeap && (|hitVec);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitmap   <= '0;
      qCount   <= '0;
      curAddr  <= '0;
      wordIdx  <= '0;
      revCount <= '0;
    end else begin
      if (strobes.acceptFree) begin
        bitmap <= bitmap | paintMask;
        qCount <= qCount + QCNT_W'(1);
      end
      if (strobes.loadAddr) begin
        curAddr  <= sweepBase;
        wordIdx  <= '0;
        revCount <= '0;
      end
      if (strobes.stepAddr) begin
        curAddr <= curAddr + MADDR_W'(1);
        wordIdx <= wordIdx + CNT_W'(1);
      end
      if (strobes.evalWord && revokeHit) begin
        revCount <= revCount + CNT_W'(1);
      end
      if (strobes.finish) begin
        bitmap <= '0;
        qCount <= '0;
      end
    end
  end

  assign qLast        = (qCount == QCNT_W'(QDEPTH - 1));
  assign lastWord     = ((wordIdx + CNT_W'(1)) == sweepWords);
  assign sweepEmpty   = (sweepWords == '0);
  assign memEn        = strobes.issueRead;
  assign memWe        = strobes.evalWord && revokeHit;
  assign memAddr      = curAddr;
  assign memWData     = memRData;
  assign memWTag      = 1'b0;
  assign revokedCount = revCount;
endmodule

// File: rtl/capRevoker.sv
module capRevoker
  import capRevPkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int BASE_W         = 16,
  parameter int LEN_W          = 16,
  parameter int MADDR_W        = 8,
  parameter int HEAP_BASE      = 'h1000,
  parameter int HEAP_GRANULES  = 64,
  parameter int GRANULE_BYTES  = 16,
  parameter int QDEPTH         = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeValid,
  output logic               freeReady,
  input  logic [BASE_W-1:0]  freeBase,
  input  logic [LEN_W-1:0]   freeLen,
  input  logic [MADDR_W-1:0] sweepBase,
  input  logic [MADDR_W:0]   sweepWords,
  output logic               memEn,
  output logic               memWe,
  output logic [MADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  memWData,
  output logic               memWTag,
  input  logic [WORD_W-1:0]  memRData,
  input  logic               memRTag,
  output logic               done,
  output logic [MADDR_W:0]   revokedCount
);
  sweepStrobes_t strobes;
  logic qLast, lastWord, sweepEmpty;

  capRevCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .freeValid  (freeValid),
    .qLast      (qLast),
    .lastWord   (lastWord),
    .sweepEmpty (sweepEmpty),
    .strobes    (strobes),
    .freeReady  (freeReady),
    .done       (done)
  );

  capRevDatapath #(
    .WORD_W        (WORD_W),
    .BASE_W        (BASE_W),
    .LEN_W         (LEN_W),
    .MADDR_W       (MADDR_W),
    .HEAP_BASE     (HEAP_BASE),
    .HEAP_GRANULES (HEAP_GRANULES),
    .GRANULE_BYTES (GRANULE_BYTES),
    .QDEPTH        (QDEPTH)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .freeBase     (freeBase),
    .freeLen      (freeLen),
    .sweepBase    (sweepBase),
    .sweepWords   (sweepWords),
    .memRData     (memRData),
    .memRTag      (memRTag),
    .qLast        (qLast),
    .lastWord     (lastWord),
    .sweepEmpty   (sweepEmpty),
    .memEn        (memEn),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWData     (memWData),
    .memWTag      (memWTag),
    .revokedCount (revokedCount)
  );
endmodule

// File: rtl/capRevokerChk.sv
module capRevokerChk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             freeReady,
  input logic             memEn,
  input logic             memWe,
  input logic             memWTag,
  input logic             done,
  input logic [CNT_W-1:0] revokedCount
);
  // R2: idle engine never touches memory
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    freeReady |-> (!memEn && !memWe));

  // R3: frees are refused whenever a read is in flight
  p_busy_refuses_r3: assert property (@(posedge clk) disable iff (rst)
    memEn |-> !freeReady);

  // R4: every write is a revocation
  p_write_clears_r4: assert property (@(posedge clk) disable iff (rst)
    memWe |-> !memWTag);

  // R6: a write only follows the read of the same word
  p_write_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $past(memEn && !memWe));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the count holds while idle
  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    freeReady |=> (!freeReady || $stable(revokedCount)));
endmodule

bind capRevoker capRevokerChk #(.CNT_W(MADDR_W + 1)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .freeReady    (freeReady),
  .memEn        (memEn),
  .memWe        (memWe),
  .memWTag      (memWTag),
  .done         (done),
  .revokedCount (revokedCount)
);

// File: tb/sim_capRevoker.sv
`timescale 1ns/1ps
module sim_capRevoker;
  localparam int QD    = 4;
  localparam int NW    = 48;
  localparam int SBASE = 4;
  localparam int HB    = 'h1000;
  localparam int HEND  = 'h1400;

  logic        clk = 1'b0;
  logic        rst;
  logic        freeValid;
  logic        freeReady;
  logic [15:0] freeBase;
  logic [15:0] freeLen;
  logic [7:0]  sweepBase;
  logic [8:0]  sweepWords;
  logic        memEn, memWe, memWTag;
  logic [7:0]  memAddr;
  logic [31:0] memWData;
  logic [31:0] memRData;
  logic        memRTag;
  logic        done;
  logic [8:0]  revokedCount;

  always #2.5ns clk = ~clk;

  capRevoker u0 (
    .clk(clk), .rst(rst), .freeValid(freeValid), .freeReady(freeReady),
    .freeBase(freeBase), .freeLen(freeLen), .sweepBase(sweepBase),
    .sweepWords(sweepWords), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memWTag(memWTag), .memRData(memRData),
    .memRTag(memRTag), .done(done), .revokedCount(revokedCount)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  logic [31:0] memData [256];
  logic        memTag  [256];
  logic [31:0] expData [256];
  logic        expTag  [256];

  always @(posedge clk) begin
    if (memEn) begin
      memRData <= memData[memAddr];
      memRTag  <= memTag[memAddr];
    end
    if (memWe) begin
      memData[memAddr] <= memWData;
      memTag[memAddr]  <= memWTag;
    end
  end

  function automatic logic [15:0] pickBase(input int i);
    case (i % 14)
      0: return 16'h1000;  1: return 16'h1010;  2: return 16'h1020;
      3: return 16'h1030;  4: return 16'h1040;  5: return 16'h104F;
      6: return 16'h1050;  7: return 16'h13F0;  8: return 16'h1400;
      9: return 16'h0FF0; 10: return 16'h1100; 11: return 16'h1105;
      12: return 16'h1110; default: return 16'h1200;
    endcase
  endfunction

  task automatic fillMem();
    for (int i = 0; i < 256; i++) begin
      memData[i] = {((i % 3) == 0) ? 16'h1008 : 16'(16'h2000 + i), pickBase(i)};
      memTag[i]  = (i % 7) != 5;
      expData[i] = memData[i];
      expTag[i]  = memTag[i];
    end
  endtask

  // behavioural reference: quarantine list, busy countdown
  int rB [QD];
  int rL [QD];
  int mQ = 0;
  int mBusy = 0;
  int mExpRev = 0;
  string wordReq [256];

  function automatic bit regionCovers(input int b, input int l, input int cb);
    int lo, hi;
    if (l == 0) return 0;
    lo = (b < HB) ? HB : b;
    hi = (b + l - 1 >= HEND) ? HEND - 1 : b + l - 1;
    if (lo > hi) return 0;
    return ((cb - HB) / 16 >= (lo - HB) / 16) && ((cb - HB) / 16 <= (hi - HB) / 16);
  endfunction

  task automatic predictSweep();
    mExpRev = 0;
    for (int a = 0; a < 256; a++) begin
      int cb;
      bit hit;
      cb = int'(memData[a][15:0]);
      hit = 0;
      wordReq[a] = "R5 R6 R9 R10";
      if (a >= SBASE && a < SBASE + NW && memTag[a] && cb >= HB && cb < HEND)
        for (int q = 0; q < QD; q++)
          if (regionCovers(rB[q], rL[q], cb)) hit = 1;
      if (hit) begin
        expTag[a] = 1'b0;
        mExpRev++;
        wordReq[a] = "R4 R7";
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mQ = 0;
      mBusy = 0;
    end else if (mBusy > 0) begin
      mBusy--;
    end else if (freeValid) begin
      rB[mQ] = int'(freeBase);
      rL[mQ] = int'(freeLen);
      mQ++;
      if (mQ == QD) begin
        predictSweep();
        mBusy = 2 * NW + 2;
        mQ = 0;
      end
    end
  end

  bit running = 0;

  always @(negedge clk) begin
    if (running && !rst) begin
      chk(freeReady == (mBusy == 0), (mBusy == 0) ? "R2" : "R3", "freeReady",
          freeReady, mBusy == 0);
      chk(done == (mBusy == 1), "R8", "done", done, mBusy == 1);
      if (mBusy == 0) chk(!memEn && !memWe, "R2", "idle access", {memEn, memWe}, 0);
      if (mBusy == 1) begin
        chk(revokedCount == 9'(mExpRev), "R8", "revokedCount", revokedCount, mExpRev);
        for (int a = SBASE; a < SBASE + NW; a++) begin
          chk(memTag[a] == expTag[a], wordReq[a], $sformatf("tag word %0d", a),
              memTag[a], expTag[a]);
          chk(memData[a] == expData[a], "R4", $sformatf("data word %0d", a),
              memData[a], expData[a]);
        end
      end
    end
  end

  task automatic doFree(input logic [15:0] b, input logic [15:0] l);
    freeBase  = b;
    freeLen   = l;
    freeValid = 1'b1;
    @(posedge clk);
    #1 freeValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1000000ns;
    chk(0, "R8", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    rst = 1'b1; freeValid = 1'b0; freeBase = '0; freeLen = '0;
    sweepBase = 8'(SBASE); sweepWords = 9'(NW);
    fillMem();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(freeReady == 1'b1, "R1", "freeReady after reset", freeReady, 1);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(revokedCount == '0, "R1", "revokedCount after reset", revokedCount, 0);
    chk(!memEn && !memWe, "R1", "memory idle after reset", {memEn, memWe}, 0);
    running = 1;
    @(posedge clk); #1;

    // round 1: aligned, unaligned, heap-end straddle (R10), single byte (R7)
    doFree(16'h1000, 16'd32);
    doFree(16'h1038, 16'd16);
    doFree(16'h13F8, 16'h0020);
    doFree(16'h1100, 16'd1);
    // R3: free held during sweep must be ignored
    freeBase = 16'h1110; freeLen = 16'd16; freeValid = 1'b1;
    repeat (20) @(posedge clk);
    #1 freeValid = 1'b0;
    while (mBusy != 0) @(posedge clk);
    #1;

    // round 2 (R9): fresh memory image, earlier regions must not revoke
    fillMem();
    repeat (3) @(posedge clk); #1;
    doFree(16'h1200, 16'd16);
    doFree(16'h0F00, 16'h0080);
    doFree(16'h1020, 16'h0021);
    doFree(16'h13FF, 16'd1);
    while (mBusy != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(revokedCount == 9'(mExpRev), "R8", "revokedCount held idle", revokedCount, mExpRev);
    finishRun();
  end
endmodule